// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog for a small processor system. It comes out of reset switched off and does not count. Software starts it by writing a two-byte key to the restart register. The same two-byte key, written again while the timer runs, services it and clears the count. Once started, no register write can stop it. Only the chip reset returns it to the off state.

A three-bit period field in the program register picks the time-out. The time-out is 6 · 2^BASE_SHIFT · 2^period count-clock cycles, and with the default BASE_SHIFT of 14 the shortest is 98304 cycles. The count clock is either the input clock or half of it. The choice depends on a speed-mode input and a half-rate select bit. When the count reaches the time-out, the block drives an active-low reset output for a fixed number of input-clock cycles. It then falls back to the off state.

A power-down input freezes both the count and the prescaler. An idle input is accepted and has no effect on counting. The surrounding system resets the whole chip through `rst` when it needs a cold start.

Top module: `kwd_top`

## Requirements
- R1: After `rst`, `rst_n_out` is 1 and `wd_active` is 0, and while `wd_active` is 0 no time-out ever occurs.
- R2: A restart-register write (`wr_sel`=0) of 8'h1E directly followed by a restart-register write of 8'hE1 sets `wd_active`. A different restart value between them cancels the key. A repeated 8'h1E re-arms it. An 8'hE1 with no 8'h1E before it does nothing.
- R3: While active, a completed key clears the count, so the next time-out comes a full period after that key.
- R4: Once active, no write to either register clears `wd_active` or prevents the time-out.
- R5: The period field is program-register (`wr_sel`=1) bits [2:0]. At full rate, `rst_n_out` falls exactly 6 · 2^BASE_SHIFT · 2^field clock cycles after the edge that completes the key.
- R6: `rst_n_out` stays low for exactly PULSE_LEN clock cycles. When it rises, `wd_active` is 0.
- R7: The count advances on every clock when `dbl_speed`=1 and program bit 4 is 0. Otherwise it advances on every second clock.
- R8: `idle` has no effect on counting or on the time-out.
- R9: While `pwr_down`=1 the count and prescaler hold. Counting resumes from the held value when it returns to 0.
- R10: A new period field takes effect at the next comparison without clearing the count. A count already past the new limit times out on the next count step.
- R11: `rst` returns the block to the off state from any state, including power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high chip reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = restart register, 1 = program register |
| wr_data | input | 8 | Write data |
| dbl_speed | input | 1 | 1 = double-speed clock mode |
| idle | input | 1 | Core idle indication |
| pwr_down | input | 1 | Power-down: freeze counting |
| wd_active | output | 1 | Watchdog running |
| rst_n_out | output | 1 | Active-low time-out reset pulse |

## Verification
Two events can fall on the same edge. A period-field rewrite can land on the edge where the count already exceeds the new limit. A service key can complete while the count runs through its last steps. The bench lowers the period field in mid-count and expects the reset to follow one cycle after that write. It also services the timer just before each time-out and expects no reset and a full fresh period afterwards. The power-down test holds `pwr_down` across a known number of edges and expects the time-out to move later by exactly that number.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [7:0] KEY_FIRST  = 8'h1E;
  localparam logic [7:0] KEY_SECOND = 8'hE1;
  localparam logic       SEL_RESTART = 1'b0;
  localparam logic       SEL_PROG    = 1'b1;

  typedef struct packed {
    logic       half_sel;
    logic [2:0] period;
  } prog_t;

  localparam prog_t PROG_RESET = '{half_sel: 1'b0, period: 3'd0};
endpackage

// File: rtl/kwd_key_detect.sv
module kwd_key_detect
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_restart,
  input  logic [7:0] wr_data,
  output logic       key_ok
);
  logic armed;

  assign key_ok = wr_restart && armed && (wr_data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
    end else if (wr_restart) begin
      armed <= (wr_data == KEY_FIRST);
    end
  end

  // R2: a completed key is always preceded by a first-key write
  assert_key_prefix_R2: assert property (@(posedge clk) disable iff (rst)
    key_ok |-> $past(wr_restart && wr_data == KEY_FIRST));
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler (
  input  logic clk,
  input  logic rst,
  input  logic dbl_speed,
  input  logic half_sel,
  input  logic freeze,
  output logic tick
);
  logic phase;
  logic half_rate;

  assign half_rate = !dbl_speed || half_sel;
  assign tick      = !freeze && (half_rate ? phase : 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
    end else if (!freeze) begin
      phase <= !phase;
    end
  end

  // R9: prescaler phase holds through power-down
  assert_phase_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    freeze |=> $stable(phase));
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int BASE_MULT  = 6,
  parameter int BASE_SHIFT = 14,
  parameter int PERIOD_W   = 3,
  localparam int CNT_W = $clog2(BASE_MULT) + BASE_SHIFT + (1 << PERIOD_W) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enabled,
  input  logic                hold,
  input  logic                clr,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  output logic                fire,
  output logic [CNT_W-1:0]    cnt
);
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  assign limit    = CNT_W'(BASE_MULT) << (BASE_SHIFT + int'(period));
  assign at_limit = (cnt >= limit - CNT_W'(1));
  assign fire     = enabled && !hold && !clr && tick && at_limit;

  always_ff @(posedge clk) begin
    if (rst || !enabled || hold || clr || fire) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R7: every count tick below the limit advances the count by one
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (enabled && !hold && !clr && tick && !at_limit) |=> (cnt == $past(cnt) + CNT_W'(1)));
  // R9: without a tick the count holds
  assert_hold_no_tick_R9: assert property (@(posedge clk) disable iff (rst)
    (enabled && !hold && !clr && !tick) |=> $stable(cnt));
  // R3: a completed key clears the count
  assert_service_clear_R3: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/kwd_pulse_gen.sv
module kwd_pulse_gen #(
  parameter int PULSE_LEN = 96,
  localparam int PC_W = $clog2(PULSE_LEN) + 1
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic active,
  output logic done,
  output logic rst_n_out
);
  logic [PC_W-1:0] remain;

  assign done = active && (remain == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remain    <= '0;
      rst_n_out <= 1'b1;
    end else if (!active) begin
      if (fire) begin
        active    <= 1'b1;
        remain    <= PC_W'(PULSE_LEN - 1);
        rst_n_out <= 1'b0;
      end
    end else if (done) begin
      active    <= 1'b0;
      rst_n_out <= 1'b1;
    end else begin
      remain <= remain - PC_W'(1);
    end
  end

  // R6: the pulse never lasts a single cycle
  assert_pulse_min_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_n_out) |=> !rst_n_out);
endmodule

// File: rtl/kwd_top.sv
module kwd_top
  import kwd_pkg::*;
#(
  parameter int BASE_MULT  = 6,
  parameter int BASE_SHIFT = 14,
  parameter int PULSE_LEN  = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       wr_sel,
  input  logic [7:0] wr_data,
  input  logic       dbl_speed,
  input  logic       idle,
  input  logic       pwr_down,
  output logic       wd_active,
  output logic       rst_n_out
);
  localparam int PERIOD_W = 3;
  localparam int CNT_W = $clog2(BASE_MULT) + BASE_SHIFT + (1 << PERIOD_W) + 1;

  prog_t            prog;
  logic             wr_restart;
  logic             key_ok;
  logic             tick;
  logic             fire;
  logic             pulse_active;
  logic             pulse_done;
  logic [CNT_W-1:0] cnt;

  assign wr_restart = wr_en && (wr_sel == SEL_RESTART);

  always_ff @(posedge clk) begin
    if (rst) begin
      prog <= PROG_RESET;
    end else if (wr_en && (wr_sel == SEL_PROG)) begin
      prog <= '{half_sel: wr_data[4], period: wr_data[2:0]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst || pulse_done) begin
      wd_active <= 1'b0;
    end else if (key_ok) begin
      wd_active <= 1'b1;
    end
  end

  kwd_key_detect u_key (
    .clk        (clk),
    .rst        (rst),
    .wr_restart (wr_restart),
    .wr_data    (wr_data),
    .key_ok     (key_ok)
  );

  kwd_prescaler u_pre (
    .clk       (clk),
    .rst       (rst),
    .dbl_speed (dbl_speed),
    .half_sel  (prog.half_sel),
    .freeze    (pwr_down),
    .tick      (tick)
  );

  kwd_counter #(
    .BASE_MULT  (BASE_MULT),
    .BASE_SHIFT (BASE_SHIFT),
    .PERIOD_W   (PERIOD_W)
  ) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .enabled (wd_active),
    .hold    (pulse_active),
    .clr     (key_ok),
    .tick    (tick),
    .period  (prog.period),
    .fire    (fire),
    .cnt     (cnt)
  );

  kwd_pulse_gen #(
    .PULSE_LEN (PULSE_LEN)
  ) u_pulse (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .active    (pulse_active),
    .done      (pulse_done),
    .rst_n_out (rst_n_out)
  );

  // R2: the watchdog only turns on from a second-key restart write
  assert_enable_source_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_active) |-> $past(wr_restart && wr_data == KEY_SECOND));
  // R4: while running and not pulsing, nothing switches it off
  assert_stays_on_R4: assert property (@(posedge clk) disable iff (rst)
    (wd_active && rst_n_out) |=> wd_active);
  // R1: no reset pulse starts while disabled
  assert_quiet_when_off_R1: assert property (@(posedge clk) disable iff (rst)
    (!wd_active && rst_n_out) |=> rst_n_out);
  // R6: the count is held cleared during the pulse
  assert_cleared_in_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    !rst_n_out |-> (cnt == '0));
  // R8: in idle at full rate the count keeps moving
  assert_idle_counts_R8: assert property (@(posedge clk) disable iff (rst)
    (idle && !pwr_down && wd_active && rst_n_out && dbl_speed && !prog.half_sel && !key_ok)
      |=> (cnt != $past(cnt)));
endmodule

// File: tb/kwd_top_tb_top.sv
module kwd_top_tb_top;
  localparam int MULT  = 6;
  localparam int SHIFT = 2;
  localparam int PLEN  = 96;
  localparam int BASE  = MULT << SHIFT;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_sel = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       dbl_speed = 1'b1;
  logic       idle = 1'b0;
  logic       pwr_down = 1'b0;
  logic       wd_active;
  logic       rst_n_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = !clk;

  kwd_top #(.BASE_MULT(MULT), .BASE_SHIFT(SHIFT), .PULSE_LEN(PLEN)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .dbl_speed(dbl_speed), .idle(idle), .pwr_down(pwr_down),
    .wd_active(wd_active), .rst_n_out(rst_n_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; pwr_down = 1'b0; idle = 1'b0; dbl_speed = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enable();
    wr(1'b0, 8'h1E);
    wr(1'b0, 8'hE1);
  endtask

  task automatic wait_low(output int n, input int maxc);
    n = 0;
    while (rst_n_out && n < maxc) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic idle_cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic t_reset_state();
    int n;
    do_reset();
    chk(rst_n_out == 1'b1, "R1 reset rst_n_out", rst_n_out, 1);
    chk(wd_active == 1'b0, "R1 reset wd_active", wd_active, 0);
    wait_low(n, 400);
    chk(n == 400, "R1 no time-out while off", n, 400);
  endtask

  task automatic t_key_sequence();
    do_reset();
    wr(1'b0, 8'h1E); wr(1'b0, 8'h55); wr(1'b0, 8'hE1);
    chk(wd_active == 1'b0, "R2 interrupted key", wd_active, 0);
    wr(1'b0, 8'hE1);
    chk(wd_active == 1'b0, "R2 lone second key", wd_active, 0);
    wr(1'b0, 8'h1E); wr(1'b0, 8'h1E); wr(1'b0, 8'hE1);
    chk(wd_active == 1'b1, "R2 re-armed key", wd_active, 1);
  endtask

  task automatic t_timeout(input int field, input int exp);
    int n;
    int l;
    do_reset();
    wr(1'b1, 8'(field));
    enable();
    wait_low(n, 10 * exp);
    chk(n == exp, "R5 time-out length", n, exp);
    l = 0;
    while (!rst_n_out && l < 1000) begin
      @(negedge clk);
      l++;
    end
    chk(l == PLEN, "R6 pulse length", l, PLEN);
    chk(wd_active == 1'b0, "R6 off after pulse", wd_active, 0);
  endtask

  task automatic t_half_rate(input logic ds, input logic [7:0] prog);
    int n;
    do_reset();
    dbl_speed = ds;
    wr(1'b1, prog);
    enable();
    wait_low(n, 1000);
    chk(n == 2 * BASE || n == 2 * BASE - 1, "R7 half-rate time-out", n, 2 * BASE);
  endtask

  task automatic t_service();
    int n;
    do_reset();
    enable();
    for (int i = 0; i < 5; i++) begin
      idle_cycles(BASE - 4);
      enable();
      chk(rst_n_out == 1'b1, "R3 serviced no reset", rst_n_out, 1);
    end
    wait_low(n, 1000);
    chk(n == BASE, "R3 full period after service", n, BASE);
  endtask

  task automatic t_no_disable();
    int n;
    do_reset();
    enable();
    wr(1'b0, 8'h00); wr(1'b0, 8'hFF); wr(1'b1, 8'h00); wr(1'b0, 8'h1E); wr(1'b0, 8'h55);
    chk(wd_active == 1'b1, "R4 still active", wd_active, 1);
    wait_low(n, 1000);
    chk(n == BASE - 5, "R4 time-out not delayed", n, BASE - 5);
  endtask

  task automatic t_idle();
    int n;
    do_reset();
    idle = 1'b1;
    enable();
    wait_low(n, 1000);
    chk(n == BASE, "R8 idle keeps counting", n, BASE);
    idle = 1'b0;
  endtask

  task automatic t_power_down();
    int n;
    int seen_low = 0;
    do_reset();
    enable();
    idle_cycles(10);
    pwr_down = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!rst_n_out) seen_low++;
    end
    pwr_down = 1'b0;
    chk(seen_low == 0, "R9 frozen in power-down", seen_low, 0);
    wait_low(n, 1000);
    chk(n + 110 == BASE + 100, "R9 resume from held count", n + 110, BASE + 100);
  endtask

  task automatic t_period_change();
    int n;
    do_reset();
    wr(1'b1, 8'h03);
    enable();
    idle_cycles(50);
    chk(rst_n_out == 1'b1, "R10 long period running", rst_n_out, 1);
    wr(1'b1, 8'h00);
    wait_low(n, 1000);
    chk(n == 1, "R10 new period applies at next compare", n, 1);
  endtask

  task automatic t_reset_in_pd();
    int n;
    do_reset();
    enable();
    idle_cycles(5);
    pwr_down = 1'b1;
    idle_cycles(5);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    pwr_down = 1'b0;
    chk(wd_active == 1'b0, "R11 reset from power-down", wd_active, 0);
    wait_low(n, 300);
    chk(n == 300, "R11 stays off after reset", n, 300);
  endtask

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_key_sequence();
    t_timeout(0, BASE);
    t_timeout(3, BASE << 3);
    t_timeout(7, BASE << 7);
    t_half_rate(1'b0, 8'h00);
    t_half_rate(1'b1, 8'h10);
    t_service();
    t_no_disable();
    t_idle();
    t_power_down();
    t_period_change();
    t_reset_in_pd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule